// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models how a dual-bank NOR flash device reports status while an internal program or erase runs. A host drives active-low chip-enable, output-enable and write-enable strobes, an address and write data. A write is taken on the rising edge of write-enable while chip-enable is low. The block decodes the multi-cycle unlock command sequences and follows the device through idle, program, erase, erase-suspend and program-inside-suspend. During an operation, each read returns polling bits on DQ7, DQ6 and DQ2. An active-low ready output shows whether an operation is running.

The memory array is not stored. The block keeps one programmed location, the last one completed, and reads it back. Every other location reads as erased (all ones). A cycle counter stands in for the length of each operation, set by `PROG_CYC` and `ERASE_CYC`. The address splits into a sector field (the top `SECT_W` bits) and a command field (the low 11 bits). Commands use the low data byte.

Top module: `flashStatusGen`

## Requirements
- R1: While `rstN` is low, `readyOut` is low. After `rstN` goes high, the block is in read mode with `readyOut` high, no stored location, and every address reads 8'hFF.
- R2: A program sequence is AA@555, 55@2AA, A0@555, then data@address. `readyOut` stays high through the third write. It goes low after the clock edge that detects the rising write-enable of the fourth write. It stays low for exactly `PROG_CYC` cycles.
- R3: While a program runs, a read returns bit 7 equal to the complement of bit 7 of the data being programmed, and bit 2 equal to 1. Bits 5:3 and 1:0 read 0.
- R4: While any operation is busy, bit 6 inverts on each new read strobe, counted on the falling edge of (ceN OR oeN). It reads 1 on the first busy read after reset.
- R5: The toggle bits do not advance while the read strobe stays asserted, even if the address changes.
- R6: A sector erase sequence is AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 30@sector. `readyOut` stays high through the fifth write and goes low after the sixth. The erase lasts `ERASE_CYC` cycles. Bit 7 reads 0.
- R7: While an erase is pending, bit 2 inverts on successive reads of a sector being erased. It reads 1 for any other sector.
- R8: Writing 10@555 as the sixth write marks every sector for erase.
- R9: Writing B0 during an erase suspends it. `readyOut` goes high and the erase counter holds, so the erase never finishes while suspended. A read of an erasing sector returns bit 7 = 1, a steady bit 6 = 1, and a toggling bit 2. Other sectors return array data.
- R10: A program issued while suspended makes the block busy with R3 and R4 status, and bit 2 follows R7. When it ends, the block returns to suspend. Writing 30 then resumes the erase.
- R11: While busy, every command is ignored, except B0 during an erase. A full erase sequence written during a program starts nothing.
- R12: When an operation ends, `readyOut` goes high. The programmed address reads back its data, and erased sectors read 8'hFF.
- R13: A write that breaks the unlock order sends the sequencer back to its start, and no operation begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, also the device reset |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Address; top SECT_W bits select the sector |
| wdata | input | DATA_W | Write data; commands use bits 7:0 |
| dq | output | DATA_W | Read data or polling status |
| readyOut | output | 1 | High when ready, low when busy or in reset |

## Verification
Each write acts on the clock edge after its write-enable rises. The bench therefore samples `readyOut` at the falling edge that ends each write task. Busy length is counted in falling-edge samples, which must equal the configured cycle count. A read strobe advances the toggles on the first rising edge that sees it, and `dq` follows the address combinationally. Each read samples one falling edge after the strobe is asserted, and the bench's own toggle model steps at that same point.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    M_READ  = 3'd0,
    M_PROG  = 3'd1,
    M_ERASE = 3'd2,
    M_SUSP  = 3'd3,
    M_SPROG = 3'd4
  } opMode_t;

  typedef struct packed {
    logic startProg;
    logic startErase;
    logic eraseAll;
    logic progDone;
    logic eraseDone;
  } dpCtl_t;

  localparam logic [7:0]  CMD_KEY1    = 8'hAA;
  localparam logic [7:0]  CMD_KEY2    = 8'h55;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_ERASE   = 8'h80;
  localparam logic [7:0]  CMD_SECTOR  = 8'h30;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_SUSPEND = 8'hB0;
  localparam logic [10:0] KEY_ADDR_A  = 11'h555;
  localparam logic [10:0] KEY_ADDR_B  = 11'h2AA;

endpackage

// File: rtl/flashBusSync.sv
module flashBusSync (
  input  logic clk,
  input  logic rstN,
  input  logic ceN,
  input  logic oeN,
  input  logic weN,
  output logic wrEvt,
  output logic rdStart
);
  logic weQ;
  logic rdActQ;
  logic rdAct;

  assign rdAct   = !ceN && !oeN;
  assign wrEvt   = !weQ && weN && !ceN;
  assign rdStart = rdAct && !rdActQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weQ    <= 1'b1;
      rdActQ <= 1'b0;
    end else begin
      weQ    <= weN;
      rdActQ <= rdAct;
    end
  end
endmodule

// File: rtl/flashStatusCtrl.sv
module flashStatusCtrl
  import flash_status_pkg::*;
#(
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 80
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEvt,
  input  logic [10:0] cmdAddr,
  input  logic [7:0]  cmdData,
  output opMode_t     mode,
  output dpCtl_t      ctl,
  output logic        readyOut
);
  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_K1, S_K2, S_PDATA, S_E3, S_E4, S_E5
  } seqStep_t;

  seqStep_t   step, stepNext;
  opMode_t    modeNext;
  logic [CNT_W-1:0] progCnt, eraseCnt;
  logic atA, atB, acceptCmd, isSuspend, isResume;

  assign atA       = (cmdAddr == KEY_ADDR_A);
  assign atB       = (cmdAddr == KEY_ADDR_B);
  assign acceptCmd = (mode == M_READ) || (mode == M_SUSP);
  assign isSuspend = wrEvt && (mode == M_ERASE) && (cmdData == CMD_SUSPEND);
  assign isResume  = wrEvt && (mode == M_SUSP) && (step == S_IDLE)
                     && (cmdData == CMD_SECTOR);

  always_comb begin
    stepNext = step;
    if (!acceptCmd) begin
      stepNext = S_IDLE;
    end else if (wrEvt) begin
      stepNext = S_IDLE;
      case (step)
        S_IDLE: if (atA && cmdData == CMD_KEY1) stepNext = S_K1;
        S_K1:   if (atB && cmdData == CMD_KEY2) stepNext = S_K2;
        S_K2: begin
          if (atA && cmdData == CMD_PROG)       stepNext = S_PDATA;
          else if (atA && cmdData == CMD_ERASE) stepNext = S_E3;
        end
        S_E3:   if (atA && cmdData == CMD_KEY1) stepNext = S_E4;
        S_E4:   if (atB && cmdData == CMD_KEY2) stepNext = S_E5;
        default: stepNext = S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    ctl.startProg  = wrEvt && acceptCmd && (step == S_PDATA);
    ctl.eraseAll   = atA && (cmdData == CMD_CHIP);
    ctl.startErase = wrEvt && (mode == M_READ) && (step == S_E5)
                     && ((cmdData == CMD_SECTOR) || ctl.eraseAll);
    ctl.progDone   = ((mode == M_PROG) || (mode == M_SPROG)) && (progCnt == '0);
    ctl.eraseDone  = (mode == M_ERASE) && (eraseCnt == '0);
  end

  always_comb begin
    modeNext = mode;
    case (mode)
      M_READ: begin
        if (ctl.startProg)       modeNext = M_PROG;
        else if (ctl.startErase) modeNext = M_ERASE;
      end
      M_PROG:  if (ctl.progDone) modeNext = M_READ;
      M_ERASE: begin
        if (ctl.eraseDone)       modeNext = M_READ;
        else if (isSuspend)      modeNext = M_SUSP;
      end
      M_SUSP: begin
        if (ctl.startProg)       modeNext = M_SPROG;
        else if (isResume)       modeNext = M_ERASE;
      end
      M_SPROG: if (ctl.progDone) modeNext = M_SUSP;
      default:                   modeNext = M_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= M_READ;
      step     <= S_IDLE;
      progCnt  <= '0;
      eraseCnt <= '0;
    end else begin
      mode <= modeNext;
      step <= stepNext;
      if (ctl.startProg)
        progCnt <= CNT_W'(PROG_CYC - 1);
      else if (((mode == M_PROG) || (mode == M_SPROG)) && progCnt != '0)
        progCnt <= progCnt - 1'b1;
      if (ctl.startErase)
        eraseCnt <= CNT_W'(ERASE_CYC - 1);
      else if ((mode == M_ERASE) && eraseCnt != '0)
        eraseCnt <= eraseCnt - 1'b1;
    end
  end

  assign readyOut = rstN && ((mode == M_READ) || (mode == M_SUSP));

  // R2: a program whose counter reached zero hands back to read mode
  p_prog_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_PROG && progCnt == '0) |=> (mode == M_READ));

  // R11: a running program cannot be diverted into another operation
  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_PROG) |=> (mode == M_PROG || mode == M_READ));

  // R9: erase progress is frozen while suspended
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_SUSP || mode == M_SPROG) |=> $stable(eraseCnt));

  // R10: a program inside suspend returns to suspend
  p_sprog_return_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_SPROG) |=> (mode == M_SPROG || mode == M_SUSP));
endmodule

// File: rtl/flashStatusDp.sv
module flashStatusDp
  import flash_status_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStart,
  input  opMode_t           mode,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dq
);
  localparam int NSECT = 1 << SECT_W;

  logic              tog6, tog2;
  logic [NSECT-1:0]  eraseMask;
  logic [ADDR_W-1:0] pendAddr, arrAddr;
  logic [DATA_W-1:0] pendData, arrData, arrayWord, statusWord;
  logic              arrValid, inErase, busyStatus, erasePending;
  logic [SECT_W-1:0] sectOf, arrSect;

  assign sectOf       = addr[ADDR_W-1 -: SECT_W];
  assign arrSect      = arrAddr[ADDR_W-1 -: SECT_W];
  assign inErase      = eraseMask[sectOf];
  assign busyStatus   = (mode == M_PROG) || (mode == M_ERASE) || (mode == M_SPROG);
  assign erasePending = (mode == M_ERASE) || (mode == M_SUSP) || (mode == M_SPROG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else if (rdStart) begin
      if (busyStatus)             tog6 <= ~tog6;
      if (erasePending && inErase) tog2 <= ~tog2;
    end
  end

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        eraseMask[s] <= 1'b0;
      else if (ctl.startErase)
        eraseMask[s] <= ctl.eraseAll || (sectOf == SECT_W'(s));
      else if (ctl.eraseDone)
        eraseMask[s] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr <= '0;
      pendData <= '0;
      arrAddr  <= '0;
      arrData  <= '0;
      arrValid <= 1'b0;
    end else begin
      if (ctl.startProg) begin
        pendAddr <= addr;
        pendData <= wdata;
      end
      if (ctl.progDone) begin
        arrAddr  <= pendAddr;
        arrData  <= pendData;
        arrValid <= 1'b1;
      end else if (ctl.eraseDone && eraseMask[arrSect]) begin
        arrValid <= 1'b0;
      end
    end
  end

  assign arrayWord = (arrValid && addr == arrAddr) ? arrData : '1;

  always_comb begin
    statusWord = '0;
    case (mode)
      M_PROG: begin
        statusWord[7] = ~pendData[7];
        statusWord[6] = tog6;
        statusWord[2] = 1'b1;
      end
      M_ERASE: begin
        statusWord[7] = 1'b0;
        statusWord[6] = tog6;
        statusWord[2] = inErase ? tog2 : 1'b1;
      end
      M_SUSP: begin
        statusWord[7] = 1'b1;
        statusWord[6] = 1'b1;
        statusWord[2] = tog2;
      end
      M_SPROG: begin
        statusWord[7] = ~pendData[7];
        statusWord[6] = tog6;
        statusWord[2] = inErase ? tog2 : 1'b1;
      end
      default: statusWord = '0;
    endcase
  end

  always_comb begin
    if (mode == M_READ || (mode == M_SUSP && !inErase))
      dq = arrayWord;
    else
      dq = statusWord;
  end

  // R5: toggles move only on a fresh read strobe
  p_tog_on_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rdStart |=> ($stable(tog6) && $stable(tog2)));

  // R8: an erase in progress always has at least one target sector
  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_ERASE) |-> (eraseMask != '0));
endmodule

// File: rtl/flashStatusGen.sv
module flashStatusGen
  import flash_status_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int SECT_W    = 3,
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dq,
  output logic              readyOut
);
  logic    wrEvt, rdStart;
  opMode_t mode;
  dpCtl_t  ctl;

  flashBusSync u_sync (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .wrEvt(wrEvt), .rdStart(rdStart)
  );

  flashStatusCtrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEvt(wrEvt),
    .cmdAddr(addr[10:0]), .cmdData(wdata[7:0]),
    .mode(mode), .ctl(ctl), .readyOut(readyOut)
  );

  flashStatusDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_dp (
    .clk(clk), .rstN(rstN), .rdStart(rdStart), .mode(mode), .ctl(ctl),
    .addr(addr), .wdata(wdata), .dq(dq)
  );
endmodule

// File: tb/sim_flashStatusGen.sv
module sim_flashStatusGen;
  localparam int PROG_CYC  = 40;
  localparam int ERASE_CYC = 80;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  dq;
  logic        readyOut;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  // bench model: 0 read, 1 program, 2 erase, 3 suspend, 4 program in suspend
  int          bMode = 0;
  logic [7:0]  bPend = '0;
  logic [11:0] bPendAddr = '0;
  logic [11:0] bArrAddr = '0;
  logic [7:0]  bArrData = '0;
  bit          bArrValid = 0;
  logic [7:0]  bMask = '0;
  logic        eTog6 = 1'b0, eTog2 = 1'b0;

  always #4 clk = ~clk;

  flashStatusGen #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .wdata(wdata), .dq(dq), .readyOut(readyOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expDq(input logic [11:0] a);
    logic [7:0] arr;
    logic       inS;
    arr = (bArrValid && a == bArrAddr) ? bArrData : 8'hFF;
    inS = bMask[a[11:9]];
    case (bMode)
      1:       return {~bPend[7], eTog6, 3'b000, 1'b1, 2'b00};
      2:       return {1'b0, eTog6, 3'b000, (inS ? eTog2 : 1'b1), 2'b00};
      3:       return inS ? {2'b11, 3'b000, eTog2, 2'b00} : arr;
      4:       return {~bPend[7], eTog6, 3'b000, (inS ? eTog2 : 1'b1), 2'b00};
      default: return arr;
    endcase
  endfunction

  function automatic bit modelBusy();
    return (bMode == 1) || (bMode == 2) || (bMode == 4);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); ceN = 1'b0; weN = 1'b0; addr = a; wdata = d;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b1;
  endtask

  task automatic stepTogs(input logic [11:0] a);
    if (modelBusy()) eTog6 = ~eTog6;
    if ((bMode >= 2) && bMask[a[11:9]]) eTog2 = ~eTog2;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk); addr = a; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk); stepTogs(a);
    chk(tag, dq, expDq(a));
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic progSeq(input logic [11:0] a, input logic [7:0] d);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(a, d);
    bPendAddr = a; bPend = d;
    bMode = (bMode == 3) ? 4 : 1;
  endtask

  task automatic eraseSeq(input logic [11:0] a, input logic [7:0] c);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(a, c);
    bMode = 2;
    bMask = (c == 8'h10) ? 8'hFF : (8'h01 << a[11:9]);
  endtask

  task automatic finishOp(input string tag);
    int n = 0;
    while (!readyOut && n < 4000) begin @(negedge clk); n++; end
    chk(tag, {15'd0, readyOut}, 16'd1);
    if (bMode == 1 || bMode == 4) begin
      bArrAddr = bPendAddr; bArrData = bPend; bArrValid = 1;
      bMode = (bMode == 4) ? 3 : 0;
    end else if (bMode == 2) begin
      if (bArrValid && bMask[bArrAddr[11:9]]) bArrValid = 0;
      bMask = '0; bMode = 0;
    end
  endtask

  task automatic modelReset();
    bMode = 0; bArrValid = 0; bMask = '0; eTog6 = 1'b0; eTog2 = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    logic [7:0] v1, v2;
    int n;
    void'($urandom(32'd7741));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", {15'd0, readyOut}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {15'd0, readyOut}, 16'd1);
    rd(12'h123, "R1 blank read");

    // R2: busy edge and length
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0);
    chk("R2 ready through third write", {15'd0, readyOut}, 16'd1);
    wr(12'h123, 8'h5A);
    bPendAddr = 12'h123; bPend = 8'h5A; bMode = 1;
    n = 0;
    while (!readyOut && n < 1000) begin n++; @(negedge clk); end
    chk("R2 program busy length", 16'(n), 16'(PROG_CYC));
    finishOp("R12 ready after program");
    rd(12'h123, "R12 programmed readback");
    rd(12'h124, "R12 other address blank");

    // R3 R4 R5 R11
    progSeq(12'h0A0, 8'h3C);
    rd(12'h0A0, "R3 R4 first status read");
    rd(12'h0A0, "R4 second status read");
    @(negedge clk); addr = 12'h0A0; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk); stepTogs(12'h0A0); v1 = dq;
    chk("R4 held read start", v1, expDq(12'h0A0));
    addr = 12'h700;
    @(negedge clk); v2 = dq;
    chk("R5 no advance on address change", {15'd0, v2[6]}, {15'd0, v1[6]});
    ceN = 1'b1; oeN = 1'b1;
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'hA00, 8'h30);
    finishOp("R11 program completes");
    repeat (5) @(negedge clk);
    chk("R11 erase during busy ignored", {15'd0, readyOut}, 16'd1);
    rd(12'h0A0, "R12 readback after ignored erase");
    rd(12'hA00, "R11 sector untouched");

    // R13: broken unlock order
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h56); wr(12'h555, 8'hA0); wr(12'h333, 8'h00);
    @(negedge clk);
    chk("R13 no busy after bad sequence", {15'd0, readyOut}, 16'd1);
    rd(12'h333, "R13 nothing programmed");

    // R6 R7: sector erase of sector 0
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
    chk("R6 ready through fifth write", {15'd0, readyOut}, 16'd1);
    wr(12'h010, 8'h30);
    bMode = 2; bMask = 8'h01;
    chk("R6 busy after sixth write", {15'd0, readyOut}, 16'd0);
    rd(12'h010, "R6 R7 erasing sector read");
    rd(12'h020, "R7 erasing sector toggles");
    rd(12'hA00, "R7 other sector bit2 high");

    // R9: suspend
    wr(12'h000, 8'hB0);
    bMode = 3;
    chk("R9 ready in suspend", {15'd0, readyOut}, 16'd1);
    rd(12'h010, "R9 suspended sector status");
    rd(12'h010, "R9 suspended sector bit2 toggles");
    rd(12'hA00, "R9 other sector array data");
    repeat (2 * ERASE_CYC) @(negedge clk);
    chk("R9 erase frozen in suspend", {15'd0, readyOut}, 16'd1);
    rd(12'h0A0, "R9 still suspended");

    // R10: program inside suspend, then resume
    progSeq(12'hA10, 8'h81);
    chk("R10 busy in suspend program", {15'd0, readyOut}, 16'd0);
    rd(12'hA10, "R10 status other sector");
    rd(12'h010, "R10 status erasing sector");
    finishOp("R10 suspend program done");
    rd(12'h010, "R10 back in suspend");
    rd(12'hA10, "R10 suspend program data");
    wr(12'h000, 8'h30);
    bMode = 2;
    chk("R10 resume busy", {15'd0, readyOut}, 16'd0);
    finishOp("R12 erase done");
    rd(12'h0A0, "R12 erased location blank");
    rd(12'hA10, "R12 program kept");

    // R8: chip erase
    eraseSeq(12'h555, 8'h10);
    rd(12'hE00, "R8 chip erase sector 7");
    rd(12'hE04, "R8 chip erase toggles");
    rd(12'h400, "R8 chip erase sector 2");
    finishOp("R8 chip erase done");
    rd(12'hA10, "R8 all sectors blank");

    // R3 R12: random programs
    for (int i = 0; i < 20; i++) begin
      logic [11:0] ra;
      logic [7:0]  rdv;
      ra  = 12'($urandom);
      rdv = 8'($urandom);
      progSeq(ra, rdv);
      rd(ra, "R3 random status");
      finishOp("R12 random done");
      rd(ra, "R12 random readback");
    end

    // R1: reset during a program
    progSeq(12'h222, 8'h11);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R1 ready low during reset pulse", {15'd0, readyOut}, 16'd0);
    rstN = 1'b1; modelReset();
    @(negedge clk);
    chk("R1 ready after reset pulse", {15'd0, readyOut}, 16'd1);
    rd(12'h222, "R1 reset clears state");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule